// File: doc/BRIEF.md
# SDRAM Device-Side Read/Write Data Pipeline

This block models the data path of a 16-bit synchronous DRAM as seen from its pins. Column commands arrive already decoded. They are read, write, burst stop, precharge and no-op. A read or write opens a burst of column beats over a small array that stands in for the memory banks. Read beats leave on the data output a programmable number of clocks later, either two or three. Write beats are taken from the data input in the very cycle they address.

Each byte of the 16-bit word has its own mask. On a write the mask blocks the byte in its own cycle. On a read the mask switches the byte's output enable off two cycles later, at whichever latency is set. A burst can be stopped, or replaced by a new column command, on any cycle. A write that breaks into a read discards the read data still in flight. A controller model or a memory-side testbench uses the block as the device behind a command sequencer.

Top module: `sdr_datapath`

## Requirements
- R1: While reset is asserted and just after reset, `dq_oe` is 00 and `dq_out` is 0. Every array word reads back as 0 until it is written.
- R2: `cmd` is encoded as follows: 0 no-op, 1 read, 2 write, 3 burst stop, 4 precharge, 5 to 7 no-op. A read issued in cycle t presents its beat k during cycle t+L+k, where L is 2 when `lat_sel`=0 and 3 when `lat_sel`=1.
- R3: A write beat in cycle t stores `wr_data` into the addressed word in cycle t. The upper byte [15:8] is left unchanged when `dqm_hi`=1 in cycle t, and the lower byte [7:0] is left unchanged when `dqm_lo`=1.
- R4: `len_code` 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. The burst stays inside the aligned block of that size that holds the start column. Beat k uses offset (start+k) mod size when `burst_itl`=0, and offset start XOR k when `burst_itl`=1.
- R5: `len_code`=7 gives a full-page burst. It is always sequential, wraps modulo the number of columns, and runs until it is stopped or replaced. `len_code` values 4 to 6 give a single beat. Length and order are taken when the command is given.
- R6: `dqm_hi` or `dqm_lo` high in cycle u turns off the output enable of the matching byte in cycle u+2, at either latency, and that byte of `dq_out` reads 0.
- R7: A burst stop or precharge in cycle p issues no beat in cycle p or later. For a read, every beat issued before p is still delivered, so the last one appears by cycle p+L-1. For a write, no word is written in cycle p or later.
- R8: A read or write command in any cycle starts its own burst in that cycle and ends the burst in progress.
- R9: A write command in cycle n drops every read beat due in cycle n+1 or later, so `dq_oe` is 00 in cycle n+1.
- R10: In any cycle with no read beat due, `dq_oe` is 00 and `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled and outputs launched on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded column command (encoding in R2) |
| bank | input | BANK_W | Bank of a read or write command |
| col | input | COL_W | Start column of a read or write command |
| len_code | input | 3 | Burst length code |
| burst_itl | input | 1 | 1 selects interleaved beat order |
| lat_sel | input | 1 | 0 selects read latency 2, 1 selects 3 |
| wr_data | input | 2*BYTE_W | Write data for the current beat |
| dqm_hi | input | 1 | Upper byte mask |
| dqm_lo | input | 1 | Lower byte mask |
| dq_out | output | 2*BYTE_W | Read data; a disabled byte reads 0 |
| dq_oe | output | 2 | Output enable per byte, [1] upper, [0] lower |

## Verification
On every cycle the assertions check the timing relations that stand alone:
- an enabled output always traces back to a read issued exactly L cycles earlier;
- a byte mask always blanks its byte two cycles later;
- the cycle after a write command never drives the bus;
- a stop followed by a no-op issues no beat;
- every read or write command issues a beat at once.

Data correctness can only be shown by the bench scenarios, which replay a reference array and compare each cycle's expected byte values and enables. This covers the burst address orders, masked writes keeping old bytes, the delivery of in-flight beats after a stop, and the dropped tail of a read cut by a write.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_BSTOP = 3'd3,
    CMD_PRECH = 3'd4
  } col_cmd_e;

  localparam logic [2:0] LEN_PAGE = 3'd7;

  function automatic logic is_rw(input logic [2:0] c);
    return (c == CMD_READ) || (c == CMD_WRITE);
  endfunction

  function automatic logic is_stop(input logic [2:0] c);
    return (c == CMD_BSTOP) || (c == CMD_PRECH);
  endfunction

endpackage

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_dp_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [COL_W-1:0]  col_in,
  input  logic [2:0]        len_code,
  input  logic              itl_in,
  output logic              beat_go,
  output logic              beat_wr,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col
);

  // Beats in the burst minus one, as a column mask.
  function automatic logic [COL_W-1:0] span_m1(input logic [2:0] code);
    logic [COL_W-1:0] m;
    case (code)
      3'd1:     m = COL_W'(1);
      3'd2:     m = COL_W'(3);
      3'd3:     m = COL_W'(7);
      LEN_PAGE: m = '1;
      default:  m = '0;
    endcase
    return m;
  endfunction

  // Column of beat k for a burst starting at column s.
  function automatic logic [COL_W-1:0] beat_addr(input logic [COL_W-1:0] s,
                                                 input logic [COL_W-1:0] k,
                                                 input logic [2:0]       code,
                                                 input logic             itl);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] low;
    m = span_m1(code);
    if (itl && code != LEN_PAGE) low = (s ^ k) & m;
    else                         low = (s + k) & m;
    return (s & ~m) | low;
  endfunction

  logic              act_q;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  start_q;
  logic [COL_W-1:0]  k_q;
  logic [2:0]        len_q;
  logic              itl_q;
  logic              cont_last;

  assign cont_last = (len_q != LEN_PAGE) && (k_q == span_m1(len_q));

  always_comb begin
    beat_go   = 1'b0;
    beat_wr   = wr_q;
    beat_bank = bank_q;
    beat_col  = beat_addr(start_q, k_q, len_q, itl_q);
    if (is_rw(cmd)) begin
      beat_go   = 1'b1;
      beat_wr   = (cmd == CMD_WRITE);
      beat_bank = bank_in;
      beat_col  = col_in;
    end else if (!is_stop(cmd) && act_q) begin
      beat_go = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      bank_q  <= '0;
      start_q <= '0;
      k_q     <= '0;
      len_q   <= '0;
      itl_q   <= 1'b0;
    end else if (is_rw(cmd)) begin
      act_q   <= (span_m1(len_code) != '0);
      wr_q    <= (cmd == CMD_WRITE);
      bank_q  <= bank_in;
      start_q <= col_in;
      k_q     <= COL_W'(1);
      len_q   <= len_code;
      itl_q   <= itl_in;
    end else if (is_stop(cmd)) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      k_q <= k_q + COL_W'(1);
      if (cont_last) act_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sdr_word_store.sv
module sdr_word_store #(
  parameter int AW     = 5,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_hi,
  input  logic                we_lo,
  input  logic [AW-1:0]       addr,
  input  logic [2*BYTE_W-1:0] wdata,
  output logic [2*BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [2*BYTE_W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we_hi) mem[addr][2*BYTE_W-1:BYTE_W] <= wdata[2*BYTE_W-1:BYTE_W];
      if (we_lo) mem[addr][BYTE_W-1:0]        <= wdata[BYTE_W-1:0];
    end
  end

endmodule

// File: rtl/sdr_out_pipe.sv
module sdr_out_pipe #(
  parameter int BYTE_W = 8,
  parameter int PIPE_N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [2*BYTE_W-1:0] load_data,
  input  logic                flush,
  input  logic                lat_long,
  input  logic [1:0]          mask_in,
  output logic [2*BYTE_W-1:0] dq_out,
  output logic [1:0]          dq_oe
);

  localparam int DW = 2 * BYTE_W;

  logic          s_v [PIPE_N];
  logic [DW-1:0] s_d [PIPE_N];
  logic          out_v;
  logic [DW-1:0] out_d;
  logic [1:0]    msk_d1;
  logic [1:0]    msk_d2;
  int            tap;

  assign tap = lat_long ? PIPE_N - 1 : PIPE_N - 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PIPE_N; i++) begin
        s_v[i] <= 1'b0;
        s_d[i] <= '0;
      end
      out_v <= 1'b0;
      out_d <= '0;
    end else if (flush) begin
      for (int i = 0; i < PIPE_N; i++) s_v[i] <= 1'b0;
      out_v <= 1'b0;
    end else begin
      s_v[0] <= load;
      s_d[0] <= load_data;
      for (int i = 1; i < PIPE_N; i++) begin
        s_v[i] <= s_v[i-1];
        s_d[i] <= s_d[i-1];
      end
      out_v <= s_v[tap];
      out_d <= s_d[tap];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_d1 <= 2'b00;
      msk_d2 <= 2'b00;
    end else begin
      msk_d1 <= mask_in;
      msk_d2 <= msk_d1;
    end
  end

  assign dq_oe = {2{out_v}} & ~msk_d2;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_lane
      assign dq_out[g*BYTE_W +: BYTE_W] = dq_oe[g] ? out_d[g*BYTE_W +: BYTE_W] : '0;
    end
  endgenerate

endmodule

// File: rtl/sdr_datapath.sv
module sdr_datapath
  import sdr_dp_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int BANK_W = 1,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd,
  input  logic [BANK_W-1:0]   bank,
  input  logic [COL_W-1:0]    col,
  input  logic [2:0]          len_code,
  input  logic                burst_itl,
  input  logic                lat_sel,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic                dqm_hi,
  input  logic                dqm_lo,
  output logic [2*BYTE_W-1:0] dq_out,
  output logic [1:0]          dq_oe
);

  localparam int MIN_LAT = 2;
  localparam int MAX_LAT = 3;
  localparam int PIPE_N  = MAX_LAT - 1;
  localparam int AW      = BANK_W + COL_W;

  logic                beat_go;
  logic                beat_wr;
  logic [BANK_W-1:0]   beat_bank;
  logic [COL_W-1:0]    beat_col;
  logic                issue_rd;
  logic                issue_wr;
  logic                rd_flush;
  logic [2*BYTE_W-1:0] arr_rdata;

  assign issue_rd = beat_go & ~beat_wr;
  assign issue_wr = beat_go & beat_wr;
  assign rd_flush = (cmd == CMD_WRITE);

  sdr_burst_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .bank_in   (bank),
    .col_in    (col),
    .len_code  (len_code),
    .itl_in    (burst_itl),
    .beat_go   (beat_go),
    .beat_wr   (beat_wr),
    .beat_bank (beat_bank),
    .beat_col  (beat_col)
  );

  sdr_word_store #(.AW(AW), .BYTE_W(BYTE_W)) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we_hi (issue_wr & ~dqm_hi),
    .we_lo (issue_wr & ~dqm_lo),
    .addr  ({beat_bank, beat_col}),
    .wdata (wr_data),
    .rdata (arr_rdata)
  );

  sdr_out_pipe #(.BYTE_W(BYTE_W), .PIPE_N(PIPE_N)) i_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (issue_rd),
    .load_data (arr_rdata),
    .flush     (rd_flush),
    .lat_long  (lat_sel),
    .mask_in   ({dqm_hi, dqm_lo}),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

endmodule

// File: rtl/sdr_datapath_chk.sv
module sdr_datapath_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd,
  input logic       lat_sel,
  input logic       dqm_hi,
  input logic       dqm_lo,
  input logic [1:0] dq_oe,
  input logic       issue_rd,
  input logic       issue_wr
);

  // R2
  lat_trace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 2'b00) |-> ((!lat_sel && $past(issue_rd, 2)) || (lat_sel && $past(issue_rd, 3))));

  // R6
  mask_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm_hi, 2) |-> !dq_oe[1]);

  // R6
  mask_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm_lo, 2) |-> !dq_oe[0]);

  // R9
  wr_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2) |=> (dq_oe == 2'b00));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd == 3'd3 || cmd == 3'd4) && cmd == 3'd0) |-> (!issue_rd && !issue_wr));

  // R8
  new_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) |-> issue_rd);

  // R8
  new_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2) |-> issue_wr);

endmodule

bind sdr_datapath sdr_datapath_chk i_sdr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      (cmd),
  .lat_sel  (lat_sel),
  .dqm_hi   (dqm_hi),
  .dqm_lo   (dqm_lo),
  .dq_oe    (dq_oe),
  .issue_rd (issue_rd),
  .issue_wr (issue_wr)
);

// File: tb/test_sdr_datapath.sv
`timescale 1ns/1ps
module test_sdr_datapath;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [0:0]  bank = 1'b0;
  logic [3:0]  col = 4'd0;
  logic [2:0]  len_code = 3'd0;
  logic        burst_itl = 1'b0;
  logic        lat_sel = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        dqm_hi = 1'b0;
  logic        dqm_lo = 1'b0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;

  always #2.5 clk = ~clk;

  sdr_datapath i_sdr_datapath (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .col(col),
    .len_code(len_code), .burst_itl(burst_itl), .lat_sel(lat_sel),
    .wr_data(wr_data), .dqm_hi(dqm_hi), .dqm_lo(dqm_lo),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int    nchk = 0;
  int    nerr = 0;
  int    cyc = 0;
  bit    done = 0;
  string tag = "R1";

  logic [15:0] rmem [32];
  bit          pv [16];
  logic [15:0] pd [16];
  logic [1:0]  pm [16];

  bit b_act = 0, b_wr = 0, b_itl = 0;
  int b_bank = 0, b_start = 0, b_k = 0, b_len = 1;

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int ref_addr(input int s, input int k, input int l, input bit itl);
    int base, off;
    if (l == 0) return (s + k) % 16;
    base = (s / l) * l;
    off  = s % l;
    if (itl) return base + (off ^ k);
    return base + ((off + k) % l);
  endfunction

  function automatic logic [15:0] pat(input int b, input int c, input int s);
    return 16'hA5C3 ^ 16'(c * 16'h0911) ^ 16'(b * 16'h4321) ^ 16'(s * 16'h1357);
  endfunction

  task automatic check_out();
    int s;
    logic [1:0] eo;
    logic [15:0] ed;
    s  = cyc % 16;
    eo = pv[s] ? ~pm[s] : 2'b00;
    ed = {eo[1] ? pd[s][15:8] : 8'h00, eo[0] ? pd[s][7:0] : 8'h00};
    nchk++;
    if (dq_oe !== eo || dq_out !== ed) begin
      nerr++;
      $display("FAIL %s cycle %0d: oe=%b dq=%h expected oe=%b dq=%h",
               tag, cyc, dq_oe, dq_out, eo, ed);
    end
    pv[s] = 0;
    pm[s] = 2'b00;
  endtask

  task automatic model();
    int a, idx, s;
    if (cmd == 3'd1 || cmd == 3'd2) begin
      b_act = 1; b_wr = (cmd == 3'd2); b_bank = int'(bank); b_start = int'(col);
      b_k = 0; b_len = len_of(len_code); b_itl = burst_itl;
      if (b_wr) for (int j = 1; j <= 3; j++) pv[(cyc + j) % 16] = 0;
    end else if (cmd == 3'd3 || cmd == 3'd4) begin
      b_act = 0;
    end
    if (b_act) begin
      a = ref_addr(b_start, b_k, b_len, b_itl);
      idx = b_bank * 16 + a;
      if (b_wr) begin
        if (!dqm_hi) rmem[idx][15:8] = wr_data[15:8];
        if (!dqm_lo) rmem[idx][7:0]  = wr_data[7:0];
      end else begin
        s = (cyc + (lat_sel ? 3 : 2)) % 16;
        pv[s] = 1;
        pd[s] = rmem[idx];
      end
      b_k++;
      if (b_len != 0 && b_k == b_len) b_act = 0;
    end
    pm[(cyc + 2) % 16] = {dqm_hi, dqm_lo};
  endtask

  task automatic step(input logic [2:0] c, input int b, input int cl,
                      input logic [15:0] d, input logic mh, input logic ml);
    @(negedge clk);
    check_out();
    cmd = c; bank = 1'(b); col = 4'(cl); wr_data = d; dqm_hi = mh; dqm_lo = ml;
    model();
    cyc++;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 0, 0, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic fill_bank(input int b, input int seed);
    len_code = 3'd7; burst_itl = 1'b0;
    step(3'd2, b, 0, pat(b, 0, seed), 1'b0, 1'b0);
    for (int k = 1; k < 16; k++) step(3'd0, 0, 0, pat(b, k, seed), 1'b0, 1'b0);
    step(3'd3, 0, 0, 16'hDEAD, 1'b0, 1'b0);
    nop(1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rmem[i] = 16'h0;
    for (int i = 0; i < 16; i++) begin pv[i] = 0; pd[i] = 16'h0; pm[i] = 2'b00; end

    // R1: outputs idle during and after reset
    repeat (3) @(negedge clk);
    nchk++;
    if (dq_oe !== 2'b00 || dq_out !== 16'h0) begin
      nerr++;
      $display("FAIL R1 in reset: oe=%b dq=%h expected oe=00 dq=0000", dq_oe, dq_out);
    end
    rst_n = 1'b1;
    tag = "R1";
    nop(2);
    // R1: unwritten words read as zero
    len_code = 3'd3; lat_sel = 1'b0;
    step(3'd1, 1, 3, 16'h0, 1'b0, 1'b0);
    nop(11);

    // R5: full-page write wrapping, stop data not stored (R7)
    tag = "R5/R7";
    fill_bank(0, 1);
    fill_bank(1, 2);

    // R2 and R4: sweep latency, order, length and start column
    tag = "R2/R4";
    for (int l = 0; l < 2; l++)
      for (int it = 0; it < 2; it++)
        for (int code = 0; code < 4; code++)
          for (int s = 0; s < 16; s++) begin
            lat_sel = 1'(l); burst_itl = 1'(it); len_code = 3'(code);
            step(3'd1, (s >> 1) & 1, s, 16'h0, 1'b0, 1'b0);
            nop((1 << code) - 1 + 4);
          end

    // R3: masked write bursts, then read back
    tag = "R3";
    len_code = 3'd2; burst_itl = 1'b0; lat_sel = 1'b0;
    for (int m = 0; m < 4; m++) begin
      step(3'd2, 1, 4 * m + 1, pat(1, m, 7), 1'(m & 1), 1'((m >> 1) & 1));
      for (int k = 1; k < 4; k++)
        step(3'd0, 0, 0, pat(1, k + m, 9), 1'((k ^ m) & 1), 1'(((k ^ m) >> 1) & 1));
    end
    nop(1);
    len_code = 3'd7;
    step(3'd1, 1, 0, 16'h0, 1'b0, 1'b0);
    nop(15);
    step(3'd3, 0, 0, 16'h0, 1'b0, 1'b0);
    nop(4);

    // R6: read mask pattern at both latencies
    tag = "R6";
    for (int l = 0; l < 2; l++) begin
      lat_sel = 1'(l); len_code = 3'd3; burst_itl = 1'b0;
      step(3'd1, 0, 0, 16'h0, 1'b0, 1'b1);
      for (int j = 1; j < 12; j++) step(3'd0, 0, 0, 16'h0, 1'(j % 3 == 0), 1'(j % 2 == 1));
      nop(3);
    end

    // R7: stop or precharge at each offset of a read
    tag = "R7";
    for (int l = 0; l < 2; l++)
      for (int sc = 3; sc <= 4; sc++)
        for (int off = 1; off < 7; off++) begin
          lat_sel = 1'(l); len_code = 3'd3;
          step(3'd1, 1, off, 16'h0, 1'b0, 1'b0);
          nop(off - 1);
          step(3'(sc), 0, 0, 16'h0, 1'b0, 1'b0);
          nop(5);
        end
    // R7: stop during a write burst
    lat_sel = 1'b0; len_code = 3'd3;
    step(3'd2, 0, 8, 16'h1111, 1'b0, 1'b0);
    step(3'd0, 0, 0, 16'h2222, 1'b0, 1'b0);
    step(3'd4, 0, 0, 16'h3333, 1'b0, 1'b0);
    step(3'd0, 0, 0, 16'h4444, 1'b0, 1'b0);
    step(3'd1, 0, 8, 16'h0, 1'b0, 1'b0);
    nop(11);

    // R8: new commands replacing bursts
    tag = "R8";
    for (int l = 0; l < 2; l++) begin
      lat_sel = 1'(l); len_code = 3'd3; burst_itl = 1'b1;
      step(3'd1, 0, 5, 16'h0, 1'b0, 1'b0);
      nop(2);
      step(3'd1, 1, 10, 16'h0, 1'b0, 1'b0);
      step(3'd1, 0, 2, 16'h0, 1'b0, 1'b0);
      nop(11);
      len_code = 3'd2;
      step(3'd2, 1, 12, 16'h5A5A, 1'b0, 1'b0);
      step(3'd0, 0, 0, 16'h6B6B, 1'b0, 1'b0);
      step(3'd2, 0, 12, 16'h7C7C, 1'b0, 1'b0);
      step(3'd1, 1, 12, 16'h8D8D, 1'b0, 1'b0);
      nop(6);
      step(3'd1, 0, 12, 16'h0, 1'b0, 1'b0);
      nop(7);
    end

    // R9: write cutting a read at each offset
    tag = "R9";
    for (int l = 0; l < 2; l++)
      for (int off = 1; off < 5; off++) begin
        lat_sel = 1'(l); len_code = 3'd3; burst_itl = 1'b0;
        step(3'd1, 0, 0, 16'h0, 1'b0, 1'b0);
        nop(off - 1);
        len_code = 3'd0;
        step(3'd2, 1, 15, pat(l, off, 3), 1'b0, 1'b0);
        nop(4);
        step(3'd1, 1, 15, 16'h0, 1'b0, 1'b0);
        nop(4);
      end

    // R5: reserved length codes and full-page read wrap, interleave ignored
    tag = "R5";
    lat_sel = 1'b1;
    for (int code = 4; code < 7; code++) begin
      len_code = 3'(code);
      step(3'd1, 0, 6, 16'h0, 1'b0, 1'b0);
      nop(5);
    end
    len_code = 3'd7; burst_itl = 1'b1;
    step(3'd1, 1, 9, 16'h0, 1'b0, 1'b0);
    nop(19);
    step(3'd3, 0, 0, 16'h0, 1'b0, 1'b0);
    nop(5);

    // R10: idle bus with masks toggling
    tag = "R10";
    for (int j = 0; j < 8; j++) step(3'd0, 0, 0, 16'hFFFF, 1'(j & 1), 1'((j >> 1) & 1));
    nop(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule